// File: doc/BRIEF.md
# SPI Event Interrupt Collector

This block gathers four single-cycle event pulses from an SPI transfer engine (transmit done, receive ready, receive overflow and transmit underrun). It latches each pulse into a sticky raw status register. Per-source enable bits, taken from the engine's control register, gate the latched events into a masked status register. The OR of the masked bits drives one level-sensitive interrupt line.

Software finds the pending events by reading the masked status, or the raw status when it polls. It acknowledges each event by writing ones to a clear register. A masked status of zero means the block requests no service, so several such blocks can share one interrupt line.

The enable field does not use the same bit order as the status registers. Enable field bit 0 (control bit 4, receive data) gates status bit 1, and enable field bit 1 (control bit 5, transmit data) gates status bit 0. The other two bits line up. Clearing works on single bits and leaves the other bits untouched.

Top module: `spi_irq_ctrl`

## Requirements
- R1: A pulse on an event input sets its raw status bit on the following clock edge, whatever the enables are. The raw bit positions are: bit 0 transmit done, bit 1 receive ready, bit 2 receive overflow, bit 3 transmit underrun.
- R2: A raw status bit stays set, with no further pulse, until software clears it.
- R3: A write with `reg_sel` = 2 (clear register) clears every raw bit whose `reg_wdata` bit is 1, at the next clock edge. Bits written 0 are left unchanged.
- R4: An event pulse in the same cycle as a clear write to its bit leaves that bit set.
- R5: With `reg_sel` = 1, `reg_rdata` returns the masked status. Status bit 1 is raw bit 1 AND `irq_en[0]`. Status bit 0 is raw bit 0 AND `irq_en[1]`. Status bits 2 and 3 are the raw bits ANDed with `irq_en[2]` and `irq_en[3]`. With `reg_sel` = 0, `reg_rdata` returns the raw status.
- R6: `irq_o` is high in the same cycle exactly when the masked status is nonzero. It follows changes of `irq_en` with no clock delay.
- R7: `reg_rdata` bits above bit 3 always read zero. Selecting the clear register (2) or the unused code 3 reads all zeros.
- R8: Writes with `reg_sel` 0, 1 or 3 do not change the raw status.
- R9: While `rst_n` is low the raw status is all zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_tx_done | input | 1 | Transmit-done event pulse |
| evt_rx_ready | input | 1 | Receive-ready event pulse |
| evt_rx_ovf | input | 1 | Receive-overflow event pulse |
| evt_tx_undr | input | 1 | Transmit-underrun event pulse |
| irq_en | input | 4 | Enable field from control bits 7..4 (bit 0 = receive data) |
| reg_sel | input | 2 | Register select: 0 raw, 1 masked, 2 clear, 3 unused |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| irq_o | output | 1 | Combined level interrupt request |

## Verification
An event pulse can arrive in the same clock as the clear write that targets its bit, so setting and clearing meet on one flop. The bench provokes this in directed steps, with the same bit pulsed and cleared, and with different bits pulsed and cleared. It also hits the case many more times in a long pseudo-random stretch where pulses and clear writes overlap freely. A behavioural model applies "clear, then set" on every clock and compares the raw, masked and interrupt outputs with it. Any step where a set loses to its clear shows up as a miscompare.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
   localparam int unsigned NSRC  = 4;
   localparam int unsigned SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_RAW  = 2'd0,
      SEL_MASK = 2'd1,
      SEL_CLR  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   // enable field index that gates each status bit position
   function automatic int unsigned en_index(input int unsigned status_bit);
      case (status_bit)
         0:       return 1;
         1:       return 0;
         default: return status_bit;
      endcase
   endfunction
endpackage

// File: rtl/spi_irq_latch.sv
module spi_irq_latch #(
   parameter int unsigned NBITS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] set_i,
   input  logic [NBITS-1:0] clr_i,
   output logic [NBITS-1:0] q_o
);
   for (genvar b = 0; b < NBITS; b++) begin : g_bit
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_q <= 1'b0;
         else if (set_i[b]) flag_q <= 1'b1;
         else if (clr_i[b]) flag_q <= 1'b0;
      end
      assign q_o[b] = flag_q;

      // R1
      set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> q_o[b]);
      // R4
      set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (set_i[b] && clr_i[b]) |=> q_o[b]);
      // R3
      clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[b] && !set_i[b]) |=> !q_o[b]);
      // R2
      hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i[b] && !set_i[b]) |=> $stable(q_o[b]));
   end
endmodule

// File: rtl/spi_irq_enmap.sv
module spi_irq_enmap
   import spi_irq_pkg::*;
#(
   parameter int unsigned NBITS = NSRC
) (
   input  logic [NBITS-1:0] en_field_i,
   input  logic [NBITS-1:0] raw_i,
   output logic [NBITS-1:0] masked_o
);
   for (genvar s = 0; s < NBITS; s++) begin : g_map
      localparam int unsigned EIDX = en_index(s);
      assign masked_o[s] = raw_i[s] & en_field_i[EIDX];
   end
endmodule

// File: rtl/spi_irq_rdmux.sv
module spi_irq_rdmux
   import spi_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NBITS  = NSRC
) (
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [NBITS-1:0]  raw_i,
   input  logic [NBITS-1:0]  masked_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned PAD_W = DATA_W - NBITS;

   logic [NBITS-1:0] pick;
   always_comb begin
      case (reg_sel_e'(sel_i))
         SEL_RAW:  pick = raw_i;
         SEL_MASK: pick = masked_i;
         default:  pick = '0;
      endcase
   end

   if (PAD_W > 0) begin : g_pad
      assign rdata_o = {{PAD_W{1'b0}}, pick};
   end else begin : g_nopad
      assign rdata_o = pick;
   end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
   import spi_irq_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter bit          IRQ_REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_tx_done,
   input  logic              evt_rx_ready,
   input  logic              evt_rx_ovf,
   input  logic              evt_tx_undr,
   input  logic [NSRC-1:0]   irq_en,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o
);
   if (DATA_W < NSRC) begin : g_bad_width
      $error("spi_irq_ctrl: DATA_W must be at least NSRC");
   end

   logic [NSRC-1:0] ev_vec, clr_vec, raw_q, masked;

   assign ev_vec  = {evt_tx_undr, evt_rx_ovf, evt_rx_ready, evt_tx_done};
   assign clr_vec = (reg_wr && reg_sel == SEL_CLR) ? reg_wdata[NSRC-1:0] : '0;

   if (DATA_W > NSRC) begin : g_spare
      logic unused_wbits;
      assign unused_wbits = ^reg_wdata[DATA_W-1:NSRC];
   end

   spi_irq_latch #(.NBITS(NSRC)) i_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev_vec),
      .clr_i (clr_vec),
      .q_o   (raw_q)
   );

   spi_irq_enmap #(.NBITS(NSRC)) i_enmap (
      .en_field_i (irq_en),
      .raw_i      (raw_q),
      .masked_o   (masked)
   );

   spi_irq_rdmux #(.DATA_W(DATA_W), .NBITS(NSRC)) i_rdmux (
      .sel_i    (reg_sel),
      .raw_i    (raw_q),
      .masked_i (masked),
      .rdata_o  (reg_rdata)
   );

   if (IRQ_REG_OUT) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |masked;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = |masked;

      // R6
      irq_matches_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_sel == SEL_MASK) |-> (irq_o == (reg_rdata != '0)));
   end

   // R7
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:NSRC] == '0);

   // R8
   foreign_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel != SEL_CLR && ev_vec == '0) |=> $stable(raw_q));

   // R9
   always_comb begin
      if (!rst_n) begin
         reset_quiet_chk: assert (raw_q == '0);
      end
   end
endmodule

// File: tb/test_spi_irq_ctrl.sv
`timescale 1ns/1ps
module test_spi_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        e_txd = 0, e_rxr = 0, e_ovf = 0, e_und = 0;
   logic [3:0]  en = '0;
   logic [1:0]  sel = '0;
   logic        wr = 1'b0;
   logic [31:0] wd = '0;
   logic [31:0] rd;
   logic        irq;

   int unsigned vectors = 0, errors = 0;
   logic [3:0]  m_raw = '0;
   bit          done = 0;

   always #10 clk = ~clk;

   spi_irq_ctrl i_spi_irq_ctrl (
      .clk(clk), .rst_n(rst_n),
      .evt_tx_done(e_txd), .evt_rx_ready(e_rxr), .evt_rx_ovf(e_ovf), .evt_tx_undr(e_und),
      .irq_en(en), .reg_sel(sel), .reg_wr(wr), .reg_wdata(wd),
      .reg_rdata(rd), .irq_o(irq)
   );

   function automatic logic [3:0] exp_masked(logic [3:0] r, logic [3:0] e);
      logic [3:0] m;
      m[0] = r[0] & e[1];   // transmit done gated by control bit 5
      m[1] = r[1] & e[0];   // receive ready gated by control bit 4
      m[2] = r[2] & e[2];
      m[3] = r[3] & e[3];
      return m;
   endfunction

   function automatic logic [31:0] exp_rdata(logic [3:0] r, logic [3:0] e, logic [1:0] s);
      if (s == 2'd0) return {28'd0, r};
      if (s == 2'd1) return {28'd0, exp_masked(r, e)};
      return 32'd0;
   endfunction

   // one clock: drive at negedge, compare before the edge, advance model at the edge
   task automatic step(input string tag, input logic [3:0] ev, input logic [3:0] en_v,
                       input logic [1:0] s, input logic w, input logic [31:0] d);
      logic [31:0] er;
      logic        ei;
      {e_und, e_ovf, e_rxr, e_txd} = ev;
      en = en_v; sel = s; wr = w; wd = d;
      #2;
      er = rst_n ? exp_rdata(m_raw, en_v, s) : 32'd0;
      ei = rst_n ? (exp_masked(m_raw, en_v) != 0) : 1'b0;
      vectors++;
      if (rd !== er || irq !== ei) begin
         errors++;
         $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", tag, rd, irq, er, ei);
      end
      @(posedge clk);
      if (rst_n) begin
         if (w && s == 2'd2) m_raw = m_raw & ~d[3:0];
         m_raw = m_raw | ev;
      end
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: expired expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin : main
      @(negedge clk);
      // R9: reset holds everything at zero, even with events pulsing
      step("R9", 4'b1111, 4'hF, 2'd0, 1'b0, 0);
      step("R9", 4'b1111, 4'hF, 2'd1, 1'b0, 0);
      rst_n = 1'b1;
      step("R9", 4'b0000, 4'hF, 2'd0, 1'b0, 0);

      // R1: each source, enables off, raw shows it, irq stays low
      for (int i = 0; i < 4; i++) step("R1", 4'(1 << i), 4'h0, 2'd0, 1'b0, 0);
      step("R1", 4'b0000, 4'h0, 2'd0, 1'b0, 0);
      // R2: held for several cycles
      for (int i = 0; i < 5; i++) step("R2", 4'b0000, 4'h0, 2'd0, 1'b0, 0);

      // R5/R6: one enable at a time, irq follows without delay
      for (int i = 0; i < 4; i++) step("R5", 4'b0000, 4'(1 << i), 2'd1, 1'b0, 0);
      step("R6", 4'b0000, 4'b0001, 2'd0, 1'b0, 0);
      step("R6", 4'b0000, 4'b0000, 2'd1, 1'b0, 0);

      // R3: clear bits 0 and 2, then a zero write
      step("R3", 4'b0000, 4'h0, 2'd2, 1'b1, 32'h0000_0005);
      step("R3", 4'b0000, 4'hF, 2'd0, 1'b0, 0);
      step("R3", 4'b0000, 4'h0, 2'd2, 1'b1, 32'h0000_0000);
      step("R3", 4'b0000, 4'hF, 2'd1, 1'b0, 0);
      // R6: only the transmit-data enable with receive ready pending => no irq
      step("R6", 4'b0000, 4'b0010, 2'd1, 1'b0, 0);

      // R4: event and clear on the same bit, and on different bits
      step("R4", 4'b0010, 4'h0, 2'd2, 1'b1, 32'h0000_000F);
      step("R4", 4'b0000, 4'h0, 2'd0, 1'b0, 0);
      step("R4", 4'b0100, 4'h0, 2'd2, 1'b1, 32'h0000_0002);
      step("R4", 4'b0000, 4'hF, 2'd0, 1'b0, 0);

      // R8: writes of ones through other selects do nothing
      step("R8", 4'b0000, 4'h0, 2'd0, 1'b1, 32'hFFFF_FFFF);
      step("R8", 4'b0000, 4'h0, 2'd1, 1'b1, 32'hFFFF_FFFF);
      step("R8", 4'b0000, 4'h0, 2'd3, 1'b1, 32'hFFFF_FFFF);
      step("R8", 4'b0000, 4'hF, 2'd0, 1'b0, 0);

      // R7: clear and unused selects read zero, upper bits zero
      step("R7", 4'b0000, 4'hF, 2'd2, 1'b0, 0);
      step("R7", 4'b0000, 4'hF, 2'd3, 1'b0, 0);
      step("R7", 4'b1111, 4'hF, 2'd0, 1'b0, 0);
      step("R7", 4'b0000, 4'hF, 2'd1, 1'b0, 0);
      // upper write-data bits must not clear anything
      step("R3", 4'b0000, 4'hF, 2'd2, 1'b1, 32'hFFFF_FFF0);
      step("R3", 4'b0000, 4'hF, 2'd0, 1'b0, 0);

      // mixed pseudo-random traffic, heavy on set/clear overlap (R4, R6)
      begin
         logic [31:0] lfsr = 32'hACE1_2357;
         for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step("R4", lfsr[3:0] & lfsr[7:4], lfsr[11:8], lfsr[13:12],
                 lfsr[14], {lfsr[31:20], 16'h0, lfsr[19:16]});
         end
      end
      step("R2", 4'b0000, 4'hF, 2'd0, 1'b0, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule